// File: doc/BRIEF.md
# Converter Power and Over-Temperature Control Register

This block holds the software-visible control and status word of a four-channel output converter. Software uses the word to power each channel up or down and to pick how a powered-down output is terminated. A hardware thermal comparator can raise a sticky over-temperature flag in the same word. While the flag is set, every channel is forced off and an active-low alarm pin is driven.

A serial front end delivers two pulses. The first is a control write strobe with the received 12-bit word. The second is a completion pulse for every frame. A control write does not take effect at once. It is parked, and only the completion of the next frame makes it live. That next frame may be a channel data write or a no-operation. Readback always returns the live word, thermal flag included. Once software has cleared the flag, a programmable restart delay runs before the channel enables return. This gives the analog section time to settle.

Top module: `pwr_thermal_ctl`

## Requirements
- R1: After synchronous reset, readback is 0x040 (termination select = high impedance, all power bits 0, flag 0). All channel enables are 0, all outputs float, and `alarm_n` is 1.
- R2: A control write changes neither readback nor any output. The parked value becomes live on the edge of the first later `frame_done` pulse that does not come with a new write strobe, and readback shows it in the cycle after that edge.
- R3: Bits 5..2 are the power-up bits of channels 0..3 (bit 2 = channel 0), where 1 means powered. While the flag is clear and no restart delay runs, `ch_en[i]` equals the live power bit of channel i.
- R4: Bit 6 selects termination of a disabled channel: 0 drives `ch_gnd_tie[i]`=1, 1 drives `ch_float[i]`=1. An enabled channel has both at 0.
- R5: Bits 1 and 11..7 always read 0, whatever was written. Writing 1 to bit 0 never sets the thermal flag.
- R6: `ot_in` passes through SYNC_STAGES synchronizer flops. The flag (readback bit 0) sets on the next edge, which is the third edge for the default of 2. `alarm_n` then goes 0 and every `ch_en` goes 0, while the live power bits stay readable.
- R7: The flag and alarm stay set after `ot_in` falls. Only a committed control write with bit 0 = 0 clears them. A committed write with bit 0 = 1 leaves them set.
- R8: If the synchronized over-temperature input is still high when a clear commits, the flag reads 0 for exactly one cycle and then sets again.
- R9: After the flag clears, all `ch_en` stay 0 for RESTART_DLY cycles, then follow the power bits.
- R10: A write strobe in the same cycle as `frame_done` replaces the parked value and commits nothing. The parked value commits on the following frame.
- R11: Control writes committed while the flag is set update bits 6..2 of readback. `ch_en` stays 0 until the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_stb | input | 1 | Control word received (one-cycle pulse) |
| ctl_wr_data | input | 12 | Received control word |
| frame_done | input | 1 | Any serial frame completed (one-cycle pulse) |
| ot_in | input | 1 | Asynchronous over-temperature comparator output |
| ch_en | output | 4 | Per-channel analog enable |
| ch_gnd_tie | output | 4 | Per-channel resistive tie to ground |
| ch_float | output | 4 | Per-channel high-impedance select |
| alarm_n | output | 1 | Active-low over-temperature alarm |
| rd_value | output | 12 | Live register value for readback |

## Verification
State errors in this block show up at its ports within one cycle. A wrongly committed pending word appears on `rd_value` the cycle after the completing frame. A bad flag shows on `alarm_n` and bit 0 at the same moment, and the channel enables fall in that cycle too. The restart counter only shows as the exact cycle in which the enables come back. For that reason the bench counts cycles from the clearing commit and samples one cycle on each side of the expected rise. The flag re-arm after a clear during a still-hot condition is likewise a single-cycle window on `alarm_n`.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int CH_COUNT = 4;
    localparam int REG_W    = 12;
    localparam int OT_BIT   = 0;
    localparam int RSV_BIT  = 1;
    localparam int PWR_LSB  = 2;
    localparam int TERM_BIT = PWR_LSB + CH_COUNT;

    typedef struct packed {
        logic                term_hiz;
        logic [CH_COUNT-1:0] pwr_up;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        TERM_NONE  = 2'd0,
        TERM_GND   = 2'd1,
        TERM_FLOAT = 2'd2
    } term_kind_t;

    localparam ctl_fields_t CTL_RESET = '{term_hiz: 1'b1, pwr_up: '0};

    function automatic logic [REG_W-1:0] pack_rd(input ctl_fields_t f, input logic ot);
        logic [REG_W-1:0] w;
        w = '0;
        w[OT_BIT] = ot;
        w[TERM_BIT:PWR_LSB] = f;
        return w;
    endfunction

endpackage

// File: rtl/pwrctl_sync.sv
module pwrctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrctl_stage.sv
module pwrctl_stage
    import pwrctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_done,
    output logic             commit,
    output ctl_fields_t      commit_fields,
    output logic             commit_keep_ot
);
    ctl_fields_t pend_fields;
    logic        pend_ot;
    logic        pend_valid;
    logic        unused_bits;

    assign unused_bits = ^{wr_data[RSV_BIT], wr_data[REG_W-1:TERM_BIT+1]};

    // the frame that carries the write completes in the same cycle as its strobe
    assign commit = frame_done && !wr_stb && pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_fields <= CTL_RESET;
            pend_ot     <= 1'b0;
            pend_valid  <= 1'b0;
        end else if (wr_stb) begin
            pend_fields <= ctl_fields_t'(wr_data[TERM_BIT:PWR_LSB]);
            pend_ot     <= wr_data[OT_BIT];
            pend_valid  <= 1'b1;
        end else if (commit) begin
            pend_valid  <= 1'b0;
        end
    end

    assign commit_fields  = pend_fields;
    assign commit_keep_ot = pend_ot;
endmodule

// File: rtl/pwrctl_thermal.sv
module pwrctl_thermal #(
    parameter int RESTART_DLY = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic ot_sync,
    input  logic clr_req,
    output logic flag,
    output logic hold
);
    localparam int CNT_W = $clog2(RESTART_DLY + 1);

    logic [CNT_W-1:0] restart_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag        <= 1'b0;
            restart_cnt <= '0;
        end else begin
            // clear wins this cycle; a still-hot input re-arms on the next one
            if (clr_req) flag <= 1'b0;
            else         flag <= flag | ot_sync;

            if (clr_req && flag)       restart_cnt <= CNT_W'(RESTART_DLY);
            else if (restart_cnt != 0) restart_cnt <= restart_cnt - 1'b1;
        end
    end

    assign hold = (restart_cnt != 0);
endmodule

// File: rtl/pwrctl_chan.sv
module pwrctl_chan
    import pwrctl_pkg::*;
(
    input  logic pwr_up,
    input  logic term_hiz,
    input  logic flag,
    input  logic hold,
    output logic en,
    output logic gnd_tie,
    output logic float_out
);
    term_kind_t kind;

    always_comb begin
        en = pwr_up && !flag && !hold;
        if (en)            kind = TERM_NONE;
        else if (term_hiz) kind = TERM_FLOAT;
        else               kind = TERM_GND;
        gnd_tie   = (kind == TERM_GND);
        float_out = (kind == TERM_FLOAT);
    end
endmodule

// File: rtl/pwr_thermal_ctl.sv
module pwr_thermal_ctl
    import pwrctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESTART_DLY = 500
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr_stb,
    input  logic [REG_W-1:0]    ctl_wr_data,
    input  logic                frame_done,
    input  logic                ot_in,
    output logic [CH_COUNT-1:0] ch_en,
    output logic [CH_COUNT-1:0] ch_gnd_tie,
    output logic [CH_COUNT-1:0] ch_float,
    output logic                alarm_n,
    output logic [REG_W-1:0]    rd_value
);
    logic        ot_s;
    logic        commit;
    ctl_fields_t commit_fields;
    logic        commit_keep_ot;
    logic        clr_req;
    logic        thr_flag;
    logic        thr_hold;
    ctl_fields_t live;

    pwrctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ot_in),
        .q   (ot_s)
    );

    pwrctl_stage u_stage (
        .clk            (clk),
        .rst            (rst),
        .wr_stb         (ctl_wr_stb),
        .wr_data        (ctl_wr_data),
        .frame_done     (frame_done),
        .commit         (commit),
        .commit_fields  (commit_fields),
        .commit_keep_ot (commit_keep_ot)
    );

    assign clr_req = commit && !commit_keep_ot;

    pwrctl_thermal #(.RESTART_DLY(RESTART_DLY)) u_thermal (
        .clk     (clk),
        .rst     (rst),
        .ot_sync (ot_s),
        .clr_req (clr_req),
        .flag    (thr_flag),
        .hold    (thr_hold)
    );

    always_ff @(posedge clk) begin
        if (rst)         live <= CTL_RESET;
        else if (commit) live <= commit_fields;
    end

    generate
        for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
            pwrctl_chan u_chan (
                .pwr_up    (live.pwr_up[i]),
                .term_hiz  (live.term_hiz),
                .flag      (thr_flag),
                .hold      (thr_hold),
                .en        (ch_en[i]),
                .gnd_tie   (ch_gnd_tie[i]),
                .float_out (ch_float[i])
            );
        end
    endgenerate

    assign alarm_n  = !thr_flag;
    assign rd_value = pack_rd(live, thr_flag);
endmodule

// File: rtl/pwrctl_chk.sv
module pwrctl_chk
    import pwrctl_pkg::*;
#(
    parameter int RESTART_DLY = 500
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_done,
    input logic [CH_COUNT-1:0] ch_en,
    input logic [CH_COUNT-1:0] ch_gnd_tie,
    input logic [CH_COUNT-1:0] ch_float,
    input logic [REG_W-1:0]    rd_value,
    input logic                flag,
    input logic                clr_req,
    input logic                ot_sync
);
    // R2
    commit_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_value[TERM_BIT:PWR_LSB]) |-> $past(frame_done));

    // R4
    term_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        ((ch_en & (ch_gnd_tie | ch_float)) == '0) && ((ch_gnd_tie & ch_float) == '0));

    // R6
    alarm_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        rd_value[OT_BIT] |-> (ch_en == '0));

    // R7
    sticky_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clr_req));

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req ##1 (ot_sync && !clr_req)) |=> flag);

    // R9
    restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag) && (RESTART_DLY > 0)) |-> (ch_en == '0));
endmodule

bind pwr_thermal_ctl pwrctl_chk #(.RESTART_DLY(RESTART_DLY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .ch_en      (ch_en),
    .ch_gnd_tie (ch_gnd_tie),
    .ch_float   (ch_float),
    .rd_value   (rd_value),
    .flag       (thr_flag),
    .clr_req    (clr_req),
    .ot_sync    (ot_s)
);

// File: tb/pwr_thermal_ctl_tb.sv
module pwr_thermal_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;
    localparam int NVEC       = 6;

    localparam logic [11:0] TBL_WR  [NVEC] = '{12'h03C, 12'h004, 12'h060, 12'hFFE, 12'h043, 12'h018};
    localparam logic [11:0] TBL_RD  [NVEC] = '{12'h03C, 12'h004, 12'h060, 12'h07C, 12'h040, 12'h018};
    localparam logic [3:0]  TBL_EN  [NVEC] = '{4'b1111, 4'b0001, 4'b1000, 4'b1111, 4'b0000, 4'b0110};
    localparam logic [3:0]  TBL_GND [NVEC] = '{4'b0000, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b1001};
    localparam logic [3:0]  TBL_FLT [NVEC] = '{4'b0000, 4'b0000, 4'b0111, 4'b0000, 4'b1111, 4'b0000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr_stb = 1'b0;
    logic [11:0] ctl_wr_data = '0;
    logic        frame_done = 1'b0;
    logic        ot_in = 1'b0;
    logic [3:0]  ch_en, ch_gnd_tie, ch_float;
    logic        alarm_n;
    logic [11:0] rd_value;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_thermal_ctl #(.SYNC_STAGES(2), .RESTART_DLY(DLY)) u_dut (
        .clk(clk), .rst(rst), .ctl_wr_stb(ctl_wr_stb), .ctl_wr_data(ctl_wr_data),
        .frame_done(frame_done), .ot_in(ot_in), .ch_en(ch_en), .ch_gnd_tie(ch_gnd_tie),
        .ch_float(ch_float), .alarm_n(alarm_n), .rd_value(rd_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [11:0] d);
        ctl_wr_stb = 1'b1; ctl_wr_data = d;
        tick();
        ctl_wr_stb = 1'b0;
    endtask

    task automatic frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] prev_rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rd", rd_value, 12'h040);
        check("R1 en", ch_en, 4'b0000);
        check("R1 float", ch_float, 4'b1111);
        check("R1 alarm_n", alarm_n, 1'b1);

        // table: R2 parked until frame, R3/R4/R5 field map
        prev_rd = 12'h040;
        for (int i = 0; i < NVEC; i++) begin
            ctl_write(TBL_WR[i]);
            check("R2 parked", rd_value, prev_rd);
            tick();
            check("R2 idle", rd_value, prev_rd);
            frame();
            check("R5 R3 rd", rd_value, TBL_RD[i]);
            check("R3 en", ch_en, TBL_EN[i]);
            check("R4 gnd", ch_gnd_tie, TBL_GND[i]);
            check("R4 float", ch_float, TBL_FLT[i]);
            check("R5 no flag", alarm_n, 1'b1);
            prev_rd = TBL_RD[i];
        end

        // R10 strobe together with frame_done replaces and does not commit
        ctl_write(12'h004);
        ctl_wr_stb = 1'b1; ctl_wr_data = 12'h03C; frame_done = 1'b1;
        tick();
        ctl_wr_stb = 1'b0; frame_done = 1'b0;
        check("R10 no commit", rd_value, 12'h018);
        frame();
        check("R10 replaced", rd_value, 12'h03C);
        check("R10 en", ch_en, 4'b1111);

        // R6 latency and effect
        ot_in = 1'b1;
        tick(); tick();
        check("R6 not yet", alarm_n, 1'b1);
        tick();
        check("R6 alarm", alarm_n, 1'b0);
        check("R6 rd", rd_value, 12'h03D);
        check("R6 en off", ch_en, 4'b0000);
        check("R6 gnd", ch_gnd_tie, 4'b1111);

        // R7 sticky
        ot_in = 1'b0;
        repeat (5) tick();
        check("R7 sticky", alarm_n, 1'b0);
        ctl_write(12'h03D);
        frame();
        check("R7 bit0 one keeps", alarm_n, 1'b0);

        // R11 update during alarm
        ctl_write(12'h00D);
        frame();
        check("R11 rd", rd_value, 12'h00D);
        check("R11 en", ch_en, 4'b0000);

        // R9 clear then restart delay
        ctl_write(12'h03C);
        frame();
        check("R7 released", alarm_n, 1'b1);
        check("R7 rd", rd_value, 12'h03C);
        check("R9 hold start", ch_en, 4'b0000);
        repeat (DLY-1) tick();
        check("R9 hold end", ch_en, 4'b0000);
        tick();
        check("R9 resume", ch_en, 4'b1111);

        // R8 clear while still hot
        ot_in = 1'b1;
        repeat (3) tick();
        check("R8 set", alarm_n, 1'b0);
        ctl_write(12'h03C);
        frame();
        check("R8 one cycle clear", alarm_n, 1'b1);
        tick();
        check("R8 re-armed", alarm_n, 1'b0);
        check("R8 rd", rd_value, 12'h03D);
        ot_in = 1'b0;
        repeat (3) tick();
        ctl_write(12'h03C);
        frame();
        check("R8 final clear", alarm_n, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule